// File: doc/BRIEF.md
# Line Supervision Detector

This block watches a telephone line digitally. A signed 8-bit loop-current sample arrives once per 125 µs tick. Two detectors read this one sample stream. The off-hook detector compares the sample magnitude with an upper threshold, and it can use a lower threshold as hysteresis. The ring-trip detector runs only while the line is in the ringing state. It smooths the sample with a first-order IIR low-pass filter, then compares the filtered magnitude with its own threshold.

Each raw decision feeds its own debounce timer. The timer counts in 1.25 ms steps, ten ticks per step. A debounced status bit follows its raw decision only after that decision has held for the whole interval. Each edge of a debounced bit, rising or falling, can set an interrupt-pending bit. Writing 1 to a pending bit clears it.

The A/D converter and the analog linefeed are outside this block.

Top module: `line_supervisor`

## Requirements
- R1: After reset, all outputs are 0: both raw bits, both debounced bits, both pending bits and the interrupt line.
- R2: The block samples on each tick with `tick_i`=1. With hysteresis off, the off-hook raw bit becomes 1 when |sample| >= `lc_thr_hi_i`, else 0. |sample| is the two's-complement magnitude, so -128 gives 128.
- R3: With hysteresis on, a set off-hook raw bit stays set while |sample| >= `lc_thr_lo_i` and clears below it. A clear raw bit sets only when |sample| >= `lc_thr_hi_i`.
- R4: The ring filter state y starts at 0. On each tick while `line_state_i` = 3'b100 (ringing), y becomes y + ((sample - y) >>> `rt_shift_i`), using an arithmetic shift that rounds toward minus infinity.
- R5: On a tick in any other line state (000 open, 001 forward active, 010 forward on-hook transmit, 011 tip open, 101 reverse active, 110 reverse on-hook transmit, 111 ring open), y returns to 0 and the ring-trip raw bit becomes 0.
- R6: While ringing, the ring-trip raw bit becomes 1 when |y| >= `rt_thr_i`, where y is the newly updated filter value.
- R7: Let N be the 7-bit debounce code for a detector. Its debounced bit takes the raw decision's value on the (N*10+1)-th consecutive tick on which that decision differs from it. Any tick on which the two agree restarts the count. N = 0 therefore flips the bit on the first differing tick.
- R8: Every change of a debounced bit, in either direction, sets its pending bit when the matching enable bit is 1. Bit 0 of `irq_en_i`, `irq_clr_i` and `irq_pend_o` belongs to off-hook, and bit 1 belongs to ring trip.
- R9: A 1 on an `irq_clr_i` bit clears that pending bit. A set in the same cycle takes priority over the clear. While the enable bit is 0, no new set occurs, but a pending bit that is already set stays set.
- R10: `irq_o` is 1 exactly when at least one pending bit is 1.
- R11: Between ticks, sample and threshold inputs have no effect: raw bits, debounced bits and pending bits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample strobe, one cycle per 125 µs |
| sample_i | input | 8 | Signed loop-current sample |
| line_state_i | input | 3 | Linefeed state code, 3'b100 = ringing |
| hyst_en_i | input | 1 | Enables off-hook hysteresis |
| lc_thr_hi_i | input | 8 | Off-hook upper threshold |
| lc_thr_lo_i | input | 8 | Off-hook lower threshold |
| rt_thr_i | input | 8 | Ring-trip threshold |
| rt_shift_i | input | 3 | Filter shift k |
| lc_dbi_i | input | 7 | Off-hook debounce code, 1.25 ms per step |
| rt_dbi_i | input | 7 | Ring-trip debounce code, 1.25 ms per step |
| irq_en_i | input | 2 | Interrupt enables |
| irq_clr_i | input | 2 | Write-1-clear strobes |
| lc_raw_o | output | 1 | Off-hook raw decision |
| rt_raw_o | output | 1 | Ring-trip raw decision |
| lc_det_o | output | 1 | Debounced off-hook |
| rt_det_o | output | 1 | Debounced ring trip |
| irq_pend_o | output | 2 | Interrupt-pending bits |
| irq_o | output | 1 | OR of pending bits |

## Verification
The hardest state to reach is a debounced bit that flips at the exact end of its interval. A random sample almost never holds one decision for eleven or more consecutive ticks. To reach it, the stimulus changes the sample on only about one tick in eight, and it keeps the debounce codes in the range 0 to 2. The ring-trip path adds a second difficulty: the filtered value must build up across several ringing ticks. So the line state is biased toward ringing, with occasional exits that reset the filter. Directed steps cover the remaining cases: a clear in the same cycle as a new edge, a sample of -128, and a hysteresis band traversal.

// File: rtl/lsv_pkg.sv
package lsv_pkg;
  localparam logic [2:0] LS_RINGING = 3'b100;
  localparam int IRQ_LC = 0;
  localparam int IRQ_RT = 1;
  localparam int IRQ_N  = 2;
endpackage

// File: rtl/lsv_lpf.sv
module lsv_lpf #(
  parameter int SMP_W = 8,
  parameter int SH_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    run_i,
  input  logic signed [SMP_W-1:0] x_i,
  input  logic [SH_W-1:0]         shift_i,
  output logic signed [SMP_W-1:0] y_nxt_o
);
  logic signed [SMP_W-1:0] y_q;
  logic signed [SMP_W:0]   diff, step;

  assign diff    = $signed({x_i[SMP_W-1], x_i}) - $signed({y_q[SMP_W-1], y_q});
  assign step    = diff >>> shift_i;
  // result lies between y and x, so SMP_W bits suffice
  assign y_nxt_o = run_i ? (y_q + $signed(step[SMP_W-1:0])) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     y_q <= '0;
    else if (tick_i) y_q <= y_nxt_o;
  end

  p_lpf_track_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_i && shift_i == '0) |=> (y_q == $past(x_i)));
  p_lpf_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !run_i) |=> (y_q == '0));
endmodule

// File: rtl/lsv_debounce.sv
module lsv_debounce #(
  parameter int DBI_W      = 7,
  parameter int STEP_TICKS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             raw_i,
  input  logic [DBI_W-1:0] dbi_i,
  output logic             det_o,
  output logic             flip_o
);
  localparam int MAX_CNT = (2**DBI_W - 1) * STEP_TICKS;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] cnt_q, limit;

  assign limit  = CNT_W'(dbi_i) * CNT_W'(STEP_TICKS);
  assign flip_o = tick_i && (raw_i != det_o) && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      det_o <= 1'b0;
    end else if (tick_i) begin
      if (raw_i == det_o) begin
        cnt_q <= '0;
      end else if (flip_o) begin
        det_o <= raw_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(det_o));
  p_agree_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && raw_i == det_o) |=> $stable(det_o));
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_CNT));
endmodule

// File: rtl/line_supervisor.sv
module line_supervisor
  import lsv_pkg::*;
#(
  parameter int SMP_W      = 8,
  parameter int SH_W       = 3,
  parameter int DBI_W      = 7,
  parameter int STEP_TICKS = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic signed [SMP_W-1:0] sample_i,
  input  logic [2:0]              line_state_i,
  input  logic                    hyst_en_i,
  input  logic [SMP_W-1:0]        lc_thr_hi_i,
  input  logic [SMP_W-1:0]        lc_thr_lo_i,
  input  logic [SMP_W-1:0]        rt_thr_i,
  input  logic [SH_W-1:0]         rt_shift_i,
  input  logic [DBI_W-1:0]        lc_dbi_i,
  input  logic [DBI_W-1:0]        rt_dbi_i,
  input  logic [IRQ_N-1:0]        irq_en_i,
  input  logic [IRQ_N-1:0]        irq_clr_i,
  output logic                    lc_raw_o,
  output logic                    rt_raw_o,
  output logic                    lc_det_o,
  output logic                    rt_det_o,
  output logic [IRQ_N-1:0]        irq_pend_o,
  output logic                    irq_o
);
  logic                    ringing, lc_raw_nxt, rt_raw_nxt;
  logic [SMP_W-1:0]        smp_mag, y_mag;
  logic signed [SMP_W-1:0] y_nxt;
  logic [IRQ_N-1:0]        flip, det_v;

  assign ringing = (line_state_i == LS_RINGING);
  assign smp_mag = sample_i[SMP_W-1] ? $unsigned(-sample_i) : $unsigned(sample_i);
  assign y_mag   = y_nxt[SMP_W-1]    ? $unsigned(-y_nxt)    : $unsigned(y_nxt);

  assign lc_raw_nxt = (hyst_en_i && lc_raw_o) ? (smp_mag >= lc_thr_lo_i)
                                               : (smp_mag >= lc_thr_hi_i);
  assign rt_raw_nxt = ringing && (y_mag >= rt_thr_i);

  lsv_lpf #(.SMP_W(SMP_W), .SH_W(SH_W)) u_lpf (
    .clk_i, .rst_ni, .tick_i, .run_i(ringing), .x_i(sample_i),
    .shift_i(rt_shift_i), .y_nxt_o(y_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lc_raw_o <= 1'b0;
      rt_raw_o <= 1'b0;
    end else if (tick_i) begin
      lc_raw_o <= lc_raw_nxt;
      rt_raw_o <= rt_raw_nxt;
    end
  end

  lsv_debounce #(.DBI_W(DBI_W), .STEP_TICKS(STEP_TICKS)) u_db_lc (
    .clk_i, .rst_ni, .tick_i, .raw_i(lc_raw_nxt), .dbi_i(lc_dbi_i),
    .det_o(lc_det_o), .flip_o(flip[IRQ_LC])
  );
  lsv_debounce #(.DBI_W(DBI_W), .STEP_TICKS(STEP_TICKS)) u_db_rt (
    .clk_i, .rst_ni, .tick_i, .raw_i(rt_raw_nxt), .dbi_i(rt_dbi_i),
    .det_o(rt_det_o), .flip_o(flip[IRQ_RT])
  );

  assign det_v = {rt_det_o, lc_det_o};

  for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      irq_pend_o[g] <= 1'b0;
      else if (flip[g] && irq_en_i[g])  irq_pend_o[g] <= 1'b1;
      else if (irq_clr_i[g])            irq_pend_o[g] <= 1'b0;
    end

    p_pend_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_pend_o[g]) |-> (det_v[g] != $past(det_v[g])));
    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_clr_i[g] && !tick_i) |=> !irq_pend_o[g]);
  end

  assign irq_o = |irq_pend_o;

  p_ring_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ringing) |=> !rt_raw_o);
  p_raw_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(lc_raw_o) && $stable(rt_raw_o)));
endmodule

// File: tb/tb_line_supervisor.sv
module tb_line_supervisor;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic signed [7:0] smp = '0;
  logic [2:0] ls = '0;
  logic hyst = 1'b0;
  logic [7:0] hi = 8'd50, lo = 8'd30, rthr = 8'd40;
  logic [2:0] sh = '0;
  logic [6:0] lc_dbi = '0, rt_dbi = '0;
  logic [1:0] en = 2'b11, clr = '0;
  logic lc_raw, rt_raw, lc_det, rt_det, irq;
  logic [1:0] pend;

  int total = 0, bad = 0;
  int m_lc_raw = 0, m_rt_raw = 0, m_y = 0, m_lc_det = 0, m_rt_det = 0;
  int m_lc_cnt = 0, m_rt_cnt = 0, m_pend0 = 0, m_pend1 = 0;

  always #5 clk = ~clk;

  line_supervisor dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sample_i(smp),
    .line_state_i(ls), .hyst_en_i(hyst), .lc_thr_hi_i(hi), .lc_thr_lo_i(lo),
    .rt_thr_i(rthr), .rt_shift_i(sh), .lc_dbi_i(lc_dbi), .rt_dbi_i(rt_dbi),
    .irq_en_i(en), .irq_clr_i(clr), .lc_raw_o(lc_raw), .rt_raw_o(rt_raw),
    .lc_det_o(lc_det), .rt_det_o(rt_det), .irq_pend_o(pend), .irq_o(irq)
  );

  function automatic int absv(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(hyst ? "R3 lc_raw" : "R2 lc_raw", int'(lc_raw), m_lc_raw);
    chk("R6 rt_raw", int'(rt_raw), m_rt_raw);
    chk("R7 lc_det", int'(lc_det), m_lc_det);
    chk("R7 rt_det", int'(rt_det), m_rt_det);
    chk("R8 pend", int'(pend), m_pend1 * 2 + m_pend0);
    chk("R10 irq", int'(irq), int'(m_pend0 != 0 || m_pend1 != 0));
  endtask

  // one cycle; tick and clear strobes as given, model updated per requirements
  task automatic step(input logic do_tick, input logic [1:0] c);
    int lcn, rtn, ch0, ch1, lim;
    @(negedge clk);
    tick = do_tick; clr = c;
    @(negedge clk);
    tick = 1'b0; clr = '0;
    ch0 = 0; ch1 = 0;
    if (do_tick) begin
      lcn = (hyst && m_lc_raw != 0) ? int'(absv(int'(smp)) >= int'(lo))
                                    : int'(absv(int'(smp)) >= int'(hi));
      if (ls == 3'b100) begin
        m_y = m_y + ((int'(smp) - m_y) >>> sh);
        rtn = int'(absv(m_y) >= int'(rthr));
      end else begin
        m_y = 0; rtn = 0;
      end
      lim = int'(lc_dbi) * 10;
      if (lcn == m_lc_det) m_lc_cnt = 0;
      else if (m_lc_cnt >= lim) begin m_lc_det = lcn; m_lc_cnt = 0; ch0 = 1; end
      else m_lc_cnt++;
      lim = int'(rt_dbi) * 10;
      if (rtn == m_rt_det) m_rt_cnt = 0;
      else if (m_rt_cnt >= lim) begin m_rt_det = rtn; m_rt_cnt = 0; ch1 = 1; end
      else m_rt_cnt++;
      m_lc_raw = lcn; m_rt_raw = rtn;
    end
    if (ch0 != 0 && en[0]) m_pend0 = 1; else if (c[0]) m_pend0 = 0;
    if (ch1 != 0 && en[1]) m_pend1 = 1; else if (c[1]) m_pend1 = 0;
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 lc_raw", int'(lc_raw), 0); chk("R1 rt_raw", int'(rt_raw), 0);
    chk("R1 det", int'({lc_det, rt_det}), 0);
    chk("R1 pend", int'(pend), 0); chk("R1 irq", int'(irq), 0);
    rst_n = 1'b1;

    // R7 zero-interval debounce flips immediately, R8 edge sets pending
    smp = 8'sd60; ls = 3'b001;
    step(1'b1, 2'b00);
    chk("R7 immediate lc_det", int'(lc_det), 1);
    chk("R8 rise pend", int'(pend[0]), 1);
    // R9 clear then coincident set+clear
    step(1'b0, 2'b01);
    chk("R9 cleared", int'(pend[0]), 0);
    smp = 8'sd0;
    step(1'b1, 2'b01);
    chk("R9 set wins", int'(pend[0]), 1);
    step(1'b0, 2'b11);
    // R2 magnitude of -128
    hi = 8'd128; smp = -8'sd128;
    step(1'b1, 2'b00);
    chk("R2 neg128", int'(lc_raw), 1);
    // R3 hysteresis band
    hyst = 1'b1; hi = 8'd80; lo = 8'd40;
    smp = 8'sd20; step(1'b1, 2'b00); chk("R3 low", int'(lc_raw), 0);
    smp = 8'sd60; step(1'b1, 2'b00); chk("R3 below hi", int'(lc_raw), 0);
    smp = -8'sd90; step(1'b1, 2'b00); chk("R3 set", int'(lc_raw), 1);
    smp = 8'sd50; step(1'b1, 2'b00); chk("R3 hold", int'(lc_raw), 1);
    smp = 8'sd30; step(1'b1, 2'b00); chk("R3 drop", int'(lc_raw), 0);
    hyst = 1'b0;
    // R11 inputs ignored without tick
    smp = 8'sd127; hi = 8'd0;
    step(1'b0, 2'b00);
    chk("R11 lc_raw held", int'(lc_raw), 0);
    // R4 filter build-up: 50, 75, 87 with k=1, threshold 80
    ls = 3'b100; sh = 3'd1; rthr = 8'd80; smp = 8'sd100;
    step(1'b1, 2'b00); chk("R4 y=50", int'(rt_raw), 0);
    step(1'b1, 2'b00); chk("R4 y=75", int'(rt_raw), 0);
    step(1'b1, 2'b00); chk("R4 y=87", int'(rt_raw), 1);
    // R5 leaving ringing clears filter
    ls = 3'b101; step(1'b1, 2'b00); chk("R5 gated", int'(rt_raw), 0);
    ls = 3'b100; rthr = 8'd60;
    step(1'b1, 2'b00); chk("R5 restart y=50", int'(rt_raw), 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(7) == 0) smp = 8'($urandom);
      if ($urandom_range(15) == 0) ls = ($urandom_range(2) == 0) ? 3'($urandom) : 3'b100;
      if ($urandom_range(63) == 0) begin
        hyst = 1'($urandom); hi = 8'($urandom_range(20, 120));
        lo = 8'($urandom_range(0, 60)); rthr = 8'($urandom_range(10, 110));
        sh = 3'($urandom); lc_dbi = 7'($urandom_range(2));
        rt_dbi = 7'($urandom_range(2)); en = 2'($urandom);
      end
      step($urandom_range(3) != 0, ($urandom_range(5) == 0) ? 2'($urandom) : 2'b00);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule